// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block gathers interrupt events from twelve on-chip sources and presents the CPU with at most one request per cycle. Each source holds a latched event flag and an enable bit. A request is pending when both are set. Each source also has a 2-bit urgency level. Level 1 is the most urgent and level 2 comes next. Level 3 parks the source so that it can never be taken. A stored value of 0 is treated as level 1.

Software programs the enables and levels, and acknowledges events, through a write-only register bus that has eight slots. Each cycle the block finds the most urgent pending request. On equal urgency the lowest-numbered source wins. The block reports the winner's index and level. It raises a request only when the CPU's interrupt-enable flag is set and the winner's level is numerically below the CPU's current level. All outputs are combinational from registered state, so an event or write captured on one edge is visible immediately after that edge.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, all flags and enables are 0 and every level is 3. The outputs then read irqValid=0, irqIndex=0 and irqLevel=3.
- R2: A one-cycle srcEvent[k] pulse sets flag k. The flag stays set until a bus write places 1 in bit k%8 of slot k/8 (slots 0 and 1). A 0 in that bit leaves the flag unchanged.
- R3: If an event and a clear hit the same flag in the same cycle, the flag ends up set.
- R4: Slots 2 and 3 hold the enables, with source k at bit k%8 of slot 2+k/8. A flagged source whose enable bit is 0 is never reported.
- R5: Slots 4, 5 and 6 hold the levels. The level of source k sits in bits [2*(k%4)+1 : 2*(k%4)] of slot 4+k/4. A stored 0 behaves as level 1.
- R6: A pending source at level 3 never wins. When no source qualifies, the outputs are irqIndex=0, irqLevel=3 and irqValid=0.
- R7: Among qualifying sources, the one with the numerically lowest level wins.
- R8: Among qualifying sources at equal level, the lowest index wins.
- R9: irqValid is 1 only if cpuIFlag is 1 and irqLevel < cpuLevel. irqIndex and irqLevel report the winner even when irqValid is 0.
- R10: A flag, enable or level captured at a clock edge affects the outputs right after that same edge, with no further delay.
- R11: A write to slot 7 changes no enable and no level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcEvent | input | 12 | One-cycle event pulses, one bit per source |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register slot select |
| wrData | input | 8 | Write data |
| cpuIFlag | input | 1 | CPU global interrupt enable |
| cpuLevel | input | 2 | CPU current interrupt level |
| irqValid | output | 1 | Request toward the CPU |
| irqIndex | output | 4 | Winning source index |
| irqLevel | output | 2 | Winning source effective level (3 when none) |

## Verification
The assertions assume that every input is known (not X) at each rising edge. They also assume that wrAddr and wrData matter only in cycles where wrEn is high, and that srcEvent bits are single-cycle strobes. The stimulus drives every input at the falling edge from fully defined values. It draws sparse random event patterns, random slot writes including slot 7, and random CPU flag and level values. Directed sequences cover ties, level 0, and a clear that collides with an event.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int SLOT_CNT = 8;
  localparam int SLOT_W = $clog2(SLOT_CNT);
  localparam int DATA_W = 8;
  localparam int LVL_W = 2;

  typedef struct packed {
    logic [SLOT_CNT-1:0] wrSel;
    logic [DATA_W-1:0]   data;
  } regStrobe_t;
endpackage

// File: rtl/lvl_irq_ctrl_decode.sv
module lvl_irq_ctrl_decode
  import lvl_irq_pkg::*;
(
  input  logic              wrEn,
  input  logic [SLOT_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output regStrobe_t        strb
);
  always_comb begin
    strb.wrSel = '0;
    if (wrEn) strb.wrSel[wrAddr] = 1'b1;
    strb.data = wrData;
  end
endmodule

// File: rtl/lvl_irq_datapath.sv
module lvl_irq_datapath
  import lvl_irq_pkg::*;
#(
  parameter int NUM_SRC = 12,
  localparam int IDX_W = $clog2(NUM_SRC)
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  regStrobe_t         strb,
  input  logic               cpuIFlag,
  input  logic [LVL_W-1:0]   cpuLevel,
  output logic               irqValid,
  output logic [IDX_W-1:0]   irqIndex,
  output logic [LVL_W-1:0]   irqLevel
);
  localparam int BYTE_REGS   = (NUM_SRC + DATA_W - 1) / DATA_W;
  localparam int PER_LREG    = DATA_W / LVL_W;
  localparam int LVL_REGS    = (NUM_SRC + PER_LREG - 1) / PER_LREG;
  localparam int CLR_BASE    = 0;
  localparam int EN_BASE     = BYTE_REGS;
  localparam int LVL_BASE    = 2 * BYTE_REGS;
  localparam int SPARE_FIRST = LVL_BASE + LVL_REGS;
  localparam logic [LVL_W-1:0] PARKED = '1;

  logic [NUM_SRC-1:0]            flagReg;
  logic [NUM_SRC-1:0]            enReg;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvlReg;
  logic [NUM_SRC-1:0][LVL_W-1:0] effLvl;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    localparam int BYTE_I = k / DATA_W;
    localparam int BIT_I  = k % DATA_W;
    localparam int LREG   = k / PER_LREG;
    localparam int LOFF   = LVL_W * (k % PER_LREG);
    logic clrHit;
    assign clrHit = strb.wrSel[CLR_BASE + BYTE_I] & strb.data[BIT_I];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagReg[k] <= 1'b0;
        enReg[k]   <= 1'b0;
        lvlReg[k]  <= PARKED;
      end else begin
        flagReg[k] <= srcEvent[k] | (flagReg[k] & ~clrHit);
        if (strb.wrSel[EN_BASE + BYTE_I]) enReg[k] <= strb.data[BIT_I];
        if (strb.wrSel[LVL_BASE + LREG]) lvlReg[k] <= strb.data[LOFF +: LVL_W];
      end
    end

    assign effLvl[k] = (lvlReg[k] == '0) ? LVL_W'(1) : lvlReg[k];

    // R2
    event_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
      srcEvent[k] |=> flagReg[k]);
  end

  always_comb begin
    irqLevel = PARKED;
    irqIndex = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (flagReg[k] && enReg[k] && (effLvl[k] < irqLevel)) begin
        irqLevel = effLvl[k];
        irqIndex = IDX_W'(k);
      end
    end
  end

  assign irqValid = cpuIFlag && (irqLevel != PARKED) && (irqLevel < cpuLevel);

  // R9
  iflag_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> cpuIFlag);
  // R6
  parked_never_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel == PARKED) |-> (!irqValid && irqIndex == '0));
  // R4
  winner_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel != PARKED) |-> (flagReg[irqIndex] && enReg[irqIndex]));
  // R4
  enable_write_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(enReg) |-> $past(|strb.wrSel[EN_BASE +: BYTE_REGS]));

  if (SPARE_FIRST < SLOT_CNT) begin : g_spare
    // R11
    spare_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
      (|strb.wrSel[SLOT_CNT-1:SPARE_FIRST]) |=> ($stable(enReg) && $stable(lvlReg)));
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int NUM_SRC = 12,
  localparam int IDX_W = $clog2(NUM_SRC)
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic               wrEn,
  input  logic [SLOT_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               cpuIFlag,
  input  logic [LVL_W-1:0]   cpuLevel,
  output logic               irqValid,
  output logic [IDX_W-1:0]   irqIndex,
  output logic [LVL_W-1:0]   irqLevel
);
  regStrobe_t strb;

  lvl_irq_ctrl_decode decode_i (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .strb   (strb)
  );

  lvl_irq_datapath #(.NUM_SRC(NUM_SRC)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .srcEvent (srcEvent),
    .strb     (strb),
    .cpuIFlag (cpuIFlag),
    .cpuLevel (cpuLevel),
    .irqValid (irqValid),
    .irqIndex (irqIndex),
    .irqLevel (irqLevel)
  );
endmodule

// File: tb/lvl_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_tb_top;
  localparam int N = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] srcEvent = '0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic cpuIFlag = 1'b0;
  logic [1:0] cpuLevel = 2'd0;
  logic irqValid;
  logic [3:0] irqIndex;
  logic [1:0] irqLevel;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [N-1:0] mFlag = '0;
  logic [N-1:0] mEn = '0;
  logic [1:0] mLvl [N];

  always #2.5 clk = ~clk;

  lvl_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .cpuIFlag(cpuIFlag),
    .cpuLevel(cpuLevel), .irqValid(irqValid), .irqIndex(irqIndex),
    .irqLevel(irqLevel)
  );

  function automatic void predict(output logic v, output logic [3:0] idx,
                                  output logic [1:0] lvl);
    logic [1:0] best = 2'd3;
    logic [3:0] bi = 4'd0;
    for (int k = 0; k < N; k++) begin
      logic [1:0] e = (mLvl[k] == 2'd0) ? 2'd1 : mLvl[k];
      if (mFlag[k] && mEn[k] && e < best) begin
        best = e;
        bi = 4'(k);
      end
    end
    lvl = best;
    idx = bi;
    v = (best != 2'd3) && cpuIFlag && (best < cpuLevel);
  endfunction

  task automatic check(string tag);
    logic ev;
    logic [3:0] ei;
    logic [1:0] el;
    predict(ev, ei, el);
    compared++;
    if (irqValid !== ev || irqIndex !== ei || irqLevel !== el) begin
      mismatched++;
      $display("FAIL %s: got valid=%0b idx=%0d lvl=%0d, expected valid=%0b idx=%0d lvl=%0d",
               tag, irqValid, irqIndex, irqLevel, ev, ei, el);
    end
  endtask

  task automatic cyc(input logic [N-1:0] ev, input logic we, input logic [2:0] a,
                     input logic [7:0] d, input logic iflag, input logic [1:0] cl,
                     input string tag);
    @(negedge clk);
    srcEvent = ev; wrEn = we; wrAddr = a; wrData = d;
    cpuIFlag = iflag; cpuLevel = cl;
    @(posedge clk);
    for (int k = 0; k < N; k++) begin
      logic clr = we && (a == 3'(k / 8)) && d[k % 8];
      mFlag[k] = ev[k] | (mFlag[k] & ~clr);
      if (we && a == 3'(2 + k / 8)) mEn[k] = d[k % 8];
      if (we && a == 3'(4 + k / 4)) mLvl[k] = d[2 * (k % 4) +: 2];
    end
    #1;
    check(tag);
  endtask

  initial begin
    for (int k = 0; k < N; k++) mLvl[k] = 2'd3;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1 check("R1 reset state");
    // R4 flagged but disabled
    cyc(12'h020, 0, 0, 0, 1, 3, "R4 disabled source hidden");
    cyc('0, 1, 2, 8'hFF, 1, 3, "R6 enabled but parked");
    cyc('0, 1, 3, 8'h0F, 1, 3, "R6 enabled high byte parked");
    // src4=2 src5=3 src6=1 src7=2
    cyc('0, 1, 5, 8'b10_01_11_10, 1, 3, "R10 level write visible, R6 src5 parked");
    cyc(12'h090, 0, 0, 0, 1, 3, "R8 tie src4 vs src7");
    cyc(12'h040, 0, 0, 0, 1, 3, "R7 lower level src6 wins");
    cyc('0, 0, 0, 0, 0, 3, "R9 iflag low blocks");
    cyc('0, 0, 0, 0, 1, 1, "R9 cpu level not above");
    cyc('0, 0, 0, 0, 1, 2, "R9 level 1 below 2 accepted");
    cyc('0, 1, 4, 8'h00, 1, 3, "R5 zero level acts as 1");
    cyc(12'h004, 0, 0, 0, 1, 3, "R8 src2 lvl0 ties src6 lvl1");
    cyc(12'h004, 1, 0, 8'h04, 1, 3, "R3 set and clear together");
    cyc('0, 1, 0, 8'hFB, 1, 3, "R2 zero bit keeps flag");
    cyc('0, 1, 0, 8'h04, 1, 3, "R2 clear by writing one");
    cyc('0, 1, 7, 8'hFF, 1, 3, "R11 spare slot write");
    cyc('0, 1, 0, 8'h00, 1, 3, "R11 state kept after spare write");
    cyc('0, 1, 2, 8'h00, 1, 3, "R4 disable drops request");
    cyc(12'h800, 1, 3, 8'h08, 1, 3, "R4 src11 enabled while parked");
    cyc('0, 1, 6, 8'h40, 1, 3, "R5 src11 level from slot 6 top bits");
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] ev = N'($urandom & $urandom & $urandom);
      logic we = ($urandom % 10) < 3;
      cyc(ev, we, 3'($urandom), 8'($urandom), 1'($urandom), 2'($urandom),
          "R7 random mix");
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule